// File: doc/BRIEF.md
# Line-Locked Phase Comparator and Divider

This block forms the digital side of a horizontal line-lock loop. An external voltage-controlled oscillator supplies the pixel clock, and the block divides that clock down to line rate with a modulo-N horizontal counter. The modulus is 702 in one panel mode and 1050 in the other. Each time the counter wraps, the block emits a one-clock line-start strobe that later timing logic can use.

The incoming horizontal sync is active low. It passes through a two-flop synchronizer, and its edges are then detected. While the synchronized sync is low, the block drives a phase-error output toward an external loop filter. That output is three-state and is modelled as a data bit plus an output enable. The data bit is low while the counter sits below a transition count and high once the counter reaches it. The transition count lies at half of the nominal 4.7 us sync width. When the loop is locked, the low time and the high time inside the sync window are therefore equal, and any phase offset shows up as an imbalance whose sign gives the direction of the error.

A no-signal flag releases the output to high impedance while the counter keeps running freely, so the panel drive downstream stays alive. A synchronous active-high reset clears the counter and all driven outputs.

Top module: `linelock_pd`

## Requirements
- R1: `hpos` advances by one each clock and wraps to 0 after reaching N-1, where N is DIV_A (default 702) when `mode`=0 and DIV_B (default 1050) when `mode`=1. `line_start` pulses are therefore N clocks apart.
- R2: `line_start` is high for exactly one clock, in the cycle where `hpos` has just wrapped to 0. It stays low in the first cycle after reset.
- R3: `pe_oe` rises 3 clocks after the first rising edge that samples `sync_n` low. It then stays high for exactly as many clocks as `sync_n` was sampled low.
- R4: While `pe_oe` is high, `pe_d` in a cycle equals 1 if the `hpos` value of the previous cycle was at least T, and 0 otherwise. T = floor((N*4700 + 63556) / (2*63556)), which gives 26 for N=702 and 39 for N=1050.
- R5: A sync window of width W whose first compared counter value is k holds max(0, min(W, T-k)) low cycles and W minus that many high cycles. A window placed with W = 2*(T-k) is balanced, with equal low and high counts.
- R6: One clock after `no_sig` is high, `pe_oe` and `pe_d` are 0 whatever `sync_n` does, and `hpos` keeps its free-running N-clock period.
- R7: The clock after a cycle with `rst` high shows `hpos`=0 and `line_start`, `pe_d` and `pe_oe` all low. The clear applies even in the middle of a sync window.
- R8: If `mode` changes so that `hpos` is already at or beyond the new N-1, the counter is 0 on the next clock and `line_start` pulses.
- R9: `pe_d` is 0 in every cycle where `pe_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock from the external oscillator |
| rst | input | 1 | Synchronous active-high clear |
| sync_n | input | 1 | Horizontal sync, active low, asynchronous to clk |
| mode | input | 1 | Divide select: 0 gives DIV_A, 1 gives DIV_B |
| no_sig | input | 1 | Input-absent flag; releases the error output |
| hpos | output | HPW | Horizontal counter position |
| line_start | output | 1 | One-clock strobe at counter wrap |
| pe_d | output | 1 | Phase-error data bit |
| pe_oe | output | 1 | Phase-error output enable (0 = high impedance) |

## Verification
Sync windows are swept across many start phases for each divide ratio, at four widths: the sync width itself, a width that balances at the earliest reachable phase, exactly twice the transition count, and a width wider than that. The exact low and high counts distinguish a transition count that is off by one, or a window that is one cycle too long or too short, from a correct design. The sign of the imbalance shows whether the comparison direction is inverted. Further patterns cover the period measured between wrap strobes in both modes, a mode switch while the counter is beyond the smaller limit, sync windows with the no-signal flag held or raised in mid-window, and a reset that arrives inside an open window.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

  // Counter position at half the nominal sync width, rounded to whole clocks
  function automatic int unsigned mid_count(input int unsigned div,
                                            input int unsigned win_ns,
                                            input int unsigned line_ns);
    return (div * win_ns + line_ns) / (2 * line_ns);
  endfunction

  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpd_sync.sv
module lpd_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= IDLE;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= IDLE;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lpd_hcount.sv
module lpd_hcount #(
  parameter int unsigned DIV_A = 702,
  parameter int unsigned DIV_B = 1050,
  parameter int unsigned CW    = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode,
  output logic [CW-1:0] hpos,
  output logic          line_start
);

  localparam logic [CW-1:0] LAST_A = CW'(DIV_A - 1);
  localparam logic [CW-1:0] LAST_B = CW'(DIV_B - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          wrap;
  logic          ls_q;

  assign last = mode ? LAST_B : LAST_A;
  assign wrap = (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      ls_q <= 1'b0;
    end else begin
      cnt  <= wrap ? '0 : cnt + CW'(1);
      ls_q <= wrap;
    end
  end

  assign hpos       = cnt;
  assign line_start = ls_q;

  AST_HPOS_STEP: assert property (@(posedge clk) disable iff (rst)
    (hpos != '0) |-> (hpos == $past(hpos) + CW'(1)));  // R1

  AST_HPOS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (hpos >= last) |=> (hpos == '0));  // R8

  AST_LS_ALIGN: assert property (@(posedge clk) disable iff (rst)
    line_start |-> (hpos == '0));  // R2

  AST_LS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);  // R2

endmodule

// File: rtl/lpd_phase.sv
module lpd_phase #(
  parameter int unsigned CW  = 11,
  parameter int unsigned T_A = 26,
  parameter int unsigned T_B = 39
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_s,
  input  logic          mode,
  input  logic          no_sig,
  input  logic [CW-1:0] cnt,
  output logic          pe_d,
  output logic          pe_oe
);

  localparam logic [CW-1:0] TR_A = CW'(T_A);
  localparam logic [CW-1:0] TR_B = CW'(T_B);

  logic          s_prev;
  logic          in_win;
  logic          fall;
  logic          rise;
  logic          win_nx;
  logic [CW-1:0] trans;
  logic          oe_q;
  logic          d_q;

  assign trans  = mode ? TR_B : TR_A;
  assign fall   = s_prev & ~sync_s;
  assign rise   = ~s_prev & sync_s;
  assign win_nx = fall | (in_win & ~rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_prev <= 1'b1;
      in_win <= 1'b0;
      oe_q   <= 1'b0;
      d_q    <= 1'b0;
    end else begin
      s_prev <= sync_s;
      in_win <= win_nx;
      oe_q   <= win_nx & ~no_sig;
      d_q    <= win_nx & ~no_sig & (cnt >= trans);
    end
  end

  assign pe_oe = oe_q;
  assign pe_d  = d_q;

  AST_NOSIG_FLOAT: assert property (@(posedge clk) disable iff (rst)
    no_sig |=> (!pe_oe && !pe_d));  // R6

  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pe_oe |-> !pe_d);  // R9

  AST_LEVEL_ORDER: assert property (@(posedge clk) disable iff (rst)
    (pe_oe && $past(pe_oe) && $past(pe_d) && !pe_d && $stable(mode)) |-> ($past(cnt) == '0));  // R4

endmodule

// File: rtl/linelock_pd.sv
module linelock_pd
  import lpd_pkg::*;
#(
  parameter int unsigned DIV_A       = 702,
  parameter int unsigned DIV_B       = 1050,
  parameter int unsigned SYNC_NS     = 4700,
  parameter int unsigned LINE_NS     = 63556,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned HPW        = bits_for(max_u(DIV_A, DIV_B))
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sync_n,
  input  logic           mode,
  input  logic           no_sig,
  output logic [HPW-1:0] hpos,
  output logic           line_start,
  output logic           pe_d,
  output logic           pe_oe
);

  localparam int unsigned T_A = mid_count(DIV_A, SYNC_NS, LINE_NS);
  localparam int unsigned T_B = mid_count(DIV_B, SYNC_NS, LINE_NS);

  logic sync_s;

  lpd_sync #(
    .STAGES (SYNC_STAGES),
    .IDLE   (1'b1)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sync_n),
    .q   (sync_s)
  );

  lpd_hcount #(
    .DIV_A (DIV_A),
    .DIV_B (DIV_B),
    .CW    (HPW)
  ) u_hcount (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .hpos       (hpos),
    .line_start (line_start)
  );

  lpd_phase #(
    .CW  (HPW),
    .T_A (T_A),
    .T_B (T_B)
  ) u_phase (
    .clk    (clk),
    .rst    (rst),
    .sync_s (sync_s),
    .mode   (mode),
    .no_sig (no_sig),
    .cnt    (hpos),
    .pe_d   (pe_d),
    .pe_oe  (pe_oe)
  );

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      AST_RESET_CLEAR: assert (hpos == '0 && !line_start && !pe_d && !pe_oe);  // R7
    end
  end

  generate
    if (SYNC_STAGES == 2) begin : g_lat_chk
      AST_WIN_OPEN: assert property (@(posedge clk) disable iff (rst)
        $rose(pe_oe) |-> !$past(sync_n, 3));  // R3

      AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (rst)
        ($fell(pe_oe) && !$past(no_sig) && !$past(rst)) |-> $past(sync_n, 3));  // R3
    end
  endgenerate

endmodule

// File: tb/test_linelock_pd.sv
module test_linelock_pd;

  localparam int NA   = 234;
  localparam int NB   = 350;
  localparam int HPW  = 9;

  function automatic int mid(input int n);
    return (n * 4700 + 63556) / (2 * 63556);
  endfunction

  localparam int TA = mid(NA);
  localparam int TB = mid(NB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_n = 1'b1;
  logic mode = 1'b0;
  logic no_sig = 1'b0;
  logic [HPW-1:0] hpos;
  logic line_start;
  logic pe_d;
  logic pe_oe;

  int checks = 0;
  int fails = 0;
  int lo = 0;
  int hi = 0;
  int bad9 = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  linelock_pd #(.DIV_A(NA), .DIV_B(NB)) i_linelock_pd (
    .clk(clk), .rst(rst), .sync_n(sync_n), .mode(mode), .no_sig(no_sig),
    .hpos(hpos), .line_start(line_start), .pe_d(pe_d), .pe_oe(pe_oe)
  );

  always @(negedge clk) begin
    if (pe_oe) begin
      if (pe_d) hi++;
      else      lo++;
    end else if (pe_d) begin
      bad9++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_hpos(input int v);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (int'(hpos) != v && guard < 4 * NB);
  endtask

  task automatic period_check(input int n, input string req);
    int len = 0;
    int pulses = 0;
    int steps_bad = 0;
    int prev;
    do @(negedge clk); while (!line_start);
    prev = int'(hpos);
    do begin
      @(negedge clk);
      len++;
      if (line_start) pulses++;
      if (int'(hpos) != ((prev == n - 1) ? 0 : prev + 1)) steps_bad++;
      prev = int'(hpos);
    end while (!line_start);
    chk(len == n, {req, " R1 period"}, len, n);
    chk(pulses == 1 && steps_bad == 0, {req, " R2 single strobe and R1 step"}, pulses * 1000 + steps_bad, 1000);
  endtask

  task automatic run_window(input int k, input int w, input int t);
    int exp_lo;
    int exp_hi;
    wait_hpos(k - 2);
    lo = 0;
    hi = 0;
    sync_n = 1'b0;
    repeat (w) @(negedge clk);
    sync_n = 1'b1;
    repeat (6) @(negedge clk);
    exp_lo = t - k;
    if (exp_lo < 0) exp_lo = 0;
    if (exp_lo > w) exp_lo = w;
    exp_hi = w - exp_lo;
    chk(lo + hi == w, "R3 window length", lo + hi, w);
    chk(lo == exp_lo && hi == exp_hi, "R4 low/high split", lo * 1000 + hi, exp_lo * 1000 + exp_hi);
    if (exp_lo == exp_hi) chk(lo == hi, "R5 balanced window", lo - hi, 0);
    else if (exp_lo > exp_hi) chk(lo > hi, "R5 imbalance sign low-heavy", lo - hi, exp_lo - exp_hi);
    else chk(lo < hi, "R5 imbalance sign high-heavy", lo - hi, exp_lo - exp_hi);
  endtask

  task automatic sweep(input int n, input int t);
    int widths [4];
    widths[0] = t;
    widths[1] = 2 * t - 4;
    widths[2] = 2 * t;
    widths[3] = 2 * t + 5;
    for (int wi = 0; wi < 4; wi++) begin
      for (int k = 2; k <= 2 * t + 2; k++) begin
        if (k + widths[wi] <= n) run_window(k, widths[wi], t);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(hpos == '0 && !line_start && !pe_d && !pe_oe, "R7 reset state", int'(hpos), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!line_start && int'(hpos) == 1, "R2 no strobe after reset", int'(line_start) * 1000 + int'(hpos), 1);

    period_check(NA, "mode0");
    sweep(NA, TA);

    mode = 1'b1;
    repeat (2) period_check(NB, "mode1");
    sweep(NB, TB);

    wait_hpos(300);
    mode = 1'b0;
    @(negedge clk);
    chk(hpos == '0 && line_start, "R8 mode switch wrap", int'(hpos), 0);
    period_check(NA, "after R8 switch");

    no_sig = 1'b1;
    @(negedge clk);
    lo = 0;
    hi = 0;
    wait_hpos(10);
    sync_n = 1'b0;
    repeat (2 * TA) @(negedge clk);
    sync_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(lo + hi == 0, "R6 float under no-signal", lo + hi, 0);
    period_check(NA, "R6 free run");
    no_sig = 1'b0;

    wait_hpos(20);
    sync_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(pe_oe == 1'b1, "R3 window open before R6 flag", int'(pe_oe), 1);
    no_sig = 1'b1;
    @(negedge clk);
    chk(!pe_oe && !pe_d, "R6 mid-window release", int'(pe_oe) + int'(pe_d), 0);
    sync_n = 1'b1;
    repeat (6) @(negedge clk);
    no_sig = 1'b0;

    wait_hpos(30);
    sync_n = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(hpos == '0 && !line_start && !pe_d && !pe_oe, "R7 mid-window clear",
        int'(hpos) + int'(pe_oe) + int'(pe_d) + int'(line_start), 0);
    sync_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);

    chk(bad9 == 0, "R9 data quiet when floating", bad9, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule